// File: doc/BRIEF.md
# Serial Byte Receiver with Held Valid

This block turns an asynchronous serial input into bytes. The line rests high. A frame is a low start bit, then eight data bits with the least-significant bit first, then a high stop bit. Every bit lasts the same number of system clock cycles, which is the clock frequency divided by the baud rate.

The receiver watches the line while it is idle. From the first cycle it sees the line low, it times the frame and samples each of the ten bits near the middle of its period. When the frame ends, it places the byte on a ready/valid output. A pending flag keeps `outValid` high until the consumer accepts the byte. A new frame can start as soon as the stop bit has been sampled. If a new byte completes before the consumer takes the old one, the new byte replaces it.

Top module: `serial_byte_receiver`

## Requirements
- R1: During reset and on the first cycle after reset, `outValid` is low.
- R2: While the line stays high, the receiver starts no frame and `outValid` stays low.
- R3: The first clock edge at which `serialIn` is low while idle marks the start of a frame. With B cycles per bit and H = B/2 (integer division), the byte is presented (`outValid` high) after clock edge number H + 9·B + 1, counting the detecting edge as edge 1. Exactly ten sample points occur per frame.
- R4: Bit k of a frame (k = 0 for start, 9 for stop) is sampled at edge H + k·B + 1. Line values outside that sample point have no effect on the received byte.
- R5: `outData` holds the eight bits between start and stop, with the first data bit received in bit 0 and the last in bit 7.
- R6: While `outValid` is high and `outReady` is low, `outValid` stays high and `outData` stays unchanged, unless a new frame completes.
- R7: A clock edge with `outValid` and `outReady` both high accepts the byte. After it, `outValid` is low until the next frame completes.
- R8: Right after the stop bit's sample point the receiver is idle again, so frames sent with no idle gap between them are all received.
- R9: A frame that completes while a byte is still pending overwrites `outData`, and `outValid` stays high.
- R10: If a frame completes on the same edge on which the pending byte is accepted, the new byte is presented and `outValid` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| serialIn | input | 1 | Serial line, already synchronized; high when idle |
| outData | output | 8 | Received byte (width set by DATA_W) |
| outValid | output | 1 | A received byte is pending |
| outReady | input | 1 | Consumer accepts the pending byte |

## Verification
The assertions assume that `serialIn` is already synchronous to `clk` and that each frame's bits last exactly one bit period. A consumer can miss a byte only through the overwrite in R9. The bench drives the line from negative edges in whole bit periods, so every bit value is stable across its sample edge. In the noisy-frame test the bench deliberately inverts each data bit everywhere except at its exact sample cycle. The bench raises `outReady` only in deliberate windows and checks that each byte is accepted or overwritten as intended.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_BUSY = 1'b1
  } rxStateT;

  // Strobes from the control into the datapath.
  typedef struct packed {
    logic sampleBit;  // sample the line on this edge
    logic frameDone;  // this sample is the stop bit
  } rxStrobeT;

endpackage

// File: rtl/serial_rx_ctrl.sv
module serial_rx_ctrl
  import serial_rx_pkg::*;
#(
  parameter int CYCLES_PER_BIT = 16,  // must be at least 2
  parameter int DATA_W         = 8
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     serialIn,
  output rxStrobeT strobes
);

  localparam int FRAME_BITS = DATA_W + 2;
  localparam int HALF_BIT   = CYCLES_PER_BIT / 2;
  localparam int TIMER_W    = (CYCLES_PER_BIT > 2) ? $clog2(CYCLES_PER_BIT) : 1;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam logic [TIMER_W-1:0] FIRST_WAIT = TIMER_W'(HALF_BIT - 1);
  localparam logic [TIMER_W-1:0] BIT_WAIT   = TIMER_W'(CYCLES_PER_BIT - 1);
  localparam logic [IDX_W-1:0]   LAST_IDX   = IDX_W'(FRAME_BITS - 1);

  rxStateT            state;
  logic [TIMER_W-1:0] timer;
  logic [IDX_W-1:0]   bitIdx;
  logic               tick;

  assign tick = (state == RX_BUSY) && (timer == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= RX_IDLE;
      timer  <= '0;
      bitIdx <= '0;
    end else begin
      case (state)
        RX_IDLE: begin
          if (!serialIn) begin
            // Timing is counted from this edge; the first wait reaches mid-bit.
            state  <= RX_BUSY;
            timer  <= FIRST_WAIT;
            bitIdx <= '0;
          end
        end
        RX_BUSY: begin
          if (tick) begin
            timer <= BIT_WAIT;
            if (bitIdx == LAST_IDX) begin
              state  <= RX_IDLE;
              bitIdx <= '0;
            end else begin
              bitIdx <= bitIdx + 1'b1;
            end
          end else begin
            timer <= timer - 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.sampleBit = tick;
    strobes.frameDone = tick && (bitIdx == LAST_IDX);
  end

endmodule

// File: rtl/serial_rx_datapath.sv
module serial_rx_datapath
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              serialIn,
  input  rxStrobeT          strobes,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData,
  output logic              outValid
);

  // The start bit falls out of the low end. By the stop sample, the register holds the data bits.
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] holdByte;
  logic              hasByte;

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
    end else if (strobes.sampleBit && !strobes.frameDone) begin
      shiftReg <= {serialIn, shiftReg[DATA_W-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      holdByte <= '0;
      hasByte  <= 1'b0;
    end else if (strobes.frameDone) begin
      holdByte <= shiftReg;  // new byte wins over a pending or accepted one
      hasByte  <= 1'b1;
    end else if (outReady) begin
      hasByte  <= 1'b0;
    end
  end

  assign outData  = holdByte;
  assign outValid = hasByte;

endmodule

// File: rtl/serial_byte_receiver.sv
module serial_byte_receiver
  import serial_rx_pkg::*;
#(
  parameter int CLK_HZ = 100_000_000,
  parameter int BAUD   = 115_200,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              serialIn,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  input  logic              outReady
);

  localparam int CYCLES_PER_BIT = CLK_HZ / BAUD;

  rxStrobeT strobes;
  logic     sampleStrobe;
  logic     doneStrobe;

  serial_rx_ctrl #(
    .CYCLES_PER_BIT(CYCLES_PER_BIT),
    .DATA_W        (DATA_W)
  ) i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .serialIn(serialIn),
    .strobes (strobes)
  );

  serial_rx_datapath #(
    .DATA_W(DATA_W)
  ) i_datapath (
    .clk     (clk),
    .rst     (rst),
    .serialIn(serialIn),
    .strobes (strobes),
    .outReady(outReady),
    .outData (outData),
    .outValid(outValid)
  );

  assign sampleStrobe = strobes.sampleBit;
  assign doneStrobe   = strobes.frameDone;

endmodule

// File: rtl/serial_rx_checker.sv
module serial_rx_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              outValid,
  input logic              outReady,
  input logic [DATA_W-1:0] outData,
  input logic              sampleStrobe,
  input logic              doneStrobe
);

  logic [3:0] sampleCnt;

  always_ff @(posedge clk) begin
    if (rst) sampleCnt <= '0;
    else if (doneStrobe) sampleCnt <= '0;
    else if (sampleStrobe) sampleCnt <= sampleCnt + 1'b1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> !outValid);

  assert_rise_needs_frame_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(outValid) |-> $past(doneStrobe));

  assert_ten_samples_R3: assert property (@(posedge clk) disable iff (rst)
    doneStrobe |-> (sampleCnt == 4'd9));

  assert_done_is_sample_R3: assert property (@(posedge clk) disable iff (rst)
    doneStrobe |-> sampleStrobe);

  assert_hold_valid_R6: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> outValid);

  assert_hold_data_R6: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady && !doneStrobe) |=> $stable(outData));

  assert_drop_after_accept_R7: assert property (@(posedge clk) disable iff (rst)
    (outValid && outReady && !doneStrobe) |=> !outValid);

  assert_new_byte_valid_R9: assert property (@(posedge clk) disable iff (rst)
    doneStrobe |=> outValid);

endmodule

bind serial_byte_receiver serial_rx_checker #(.DATA_W(DATA_W)) i_checker (
  .clk         (clk),
  .rst         (rst),
  .outValid    (outValid),
  .outReady    (outReady),
  .outData     (outData),
  .sampleStrobe(sampleStrobe),
  .doneStrobe  (doneStrobe)
);

// File: tb/test_serial_byte_receiver.sv
`timescale 1ns/1ps
module test_serial_byte_receiver;

  localparam int CLK_HZ = 250_000_000;
  localparam int BAUD   = 15_625_000;
  localparam int CPB    = CLK_HZ / BAUD;  // 16
  localparam int HALF   = CPB / 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       serialIn = 1'b1;
  logic       outReady = 1'b0;
  logic [7:0] outData;
  logic       outValid;

  int checks = 0;
  int fails  = 0;
  logic [7:0] got[$];

  always #2 clk = ~clk;  // 250 MHz

  serial_byte_receiver #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .DATA_W(8)) i_serial_byte_receiver (
    .clk(clk), .rst(rst), .serialIn(serialIn),
    .outData(outData), .outValid(outValid), .outReady(outReady)
  );

  always @(negedge clk) if (!rst && outValid && outReady) got.push_back(outData);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic frameBit(input logic [7:0] b, input int k);
    if (k == 0) return 1'b0;
    if (k == 9) return 1'b1;
    return b[k-1];
  endfunction

  // Drive one frame from a negedge; each bit lasts CPB cycles.
  task automatic sendFrame(input logic [7:0] b, input bit noisy);
    for (int k = 0; k < 10; k++) begin
      for (int j = 0; j < CPB; j++) begin
        logic v;
        v = frameBit(b, k);
        serialIn = (noisy && k >= 1 && k <= 8 && j != HALF) ? ~v : v;
        @(negedge clk);
      end
    end
    serialIn = 1'b1;
  endtask

  task automatic accept(input string req);
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
    check(!outValid, req, outValid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    check(!outValid, "R1", outValid, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!outValid, "R1", outValid, 0);

    // R2: idle high line
    repeat (3 * CPB) @(negedge clk);
    check(!outValid, "R2", outValid, 0);

    // R3: exact latency from start detection
    fork
      sendFrame(8'hA5, 1'b0);
      begin
        repeat (HALF + 9 * CPB) @(negedge clk);
        check(!outValid, "R3 early", outValid, 0);
        @(negedge clk);
        check(outValid, "R3 on time", outValid, 1);
      end
    join
    check(outData == 8'hA5, "R3 data", outData, 8'hA5);
    accept("R7");

    // R4: data valid only at the sample cycle
    sendFrame(8'h3C, 1'b1);
    check(outValid && outData == 8'h3C, "R4", outData, 8'h3C);
    accept("R7");
    sendFrame(8'hC9, 1'b1);
    check(outValid && outData == 8'hC9, "R4", outData, 8'hC9);
    accept("R7");

    // R5: bit order
    sendFrame(8'h01, 1'b0);
    check(outData == 8'h01, "R5 lsb", outData, 8'h01);
    accept("R7");
    sendFrame(8'h80, 1'b0);
    check(outData == 8'h80, "R5 msb", outData, 8'h80);
    accept("R7");

    // Random bytes with random hold times
    for (int n = 0; n < 24; n++) begin
      logic [7:0] b;
      int hold;
      bit ok;
      b = 8'($urandom);
      hold = 1 + int'($urandom % 20);
      repeat ($urandom % 6) @(negedge clk);
      sendFrame(b, 1'b0);
      check(outValid && outData == b, "R5 random", outData, b);
      ok = 1'b1;
      for (int h = 0; h < hold; h++) begin
        @(negedge clk);
        if (!outValid || outData != b) ok = 1'b0;
      end
      check(ok, "R6 hold", outData, b);
      accept("R7 random");
    end

    // R8: back-to-back frames, consumer always ready
    got.delete();
    outReady = 1'b1;
    sendFrame(8'h11, 1'b0);
    sendFrame(8'hE7, 1'b0);
    sendFrame(8'h5A, 1'b0);
    repeat (CPB) @(negedge clk);
    outReady = 1'b0;
    check(got.size() == 3, "R8 count", got.size(), 3);
    if (got.size() == 3) begin
      check(got[0] == 8'h11, "R8 b0", got[0], 8'h11);
      check(got[1] == 8'hE7, "R8 b1", got[1], 8'hE7);
      check(got[2] == 8'h5A, "R8 b2", got[2], 8'h5A);
    end

    // R9: overwrite while pending
    sendFrame(8'h42, 1'b0);
    sendFrame(8'h99, 1'b0);
    check(outValid && outData == 8'h99, "R9", outData, 8'h99);

    // R10: accept on the same edge as the next frame completes
    got.delete();
    fork
      sendFrame(8'h6B, 1'b0);
      begin
        repeat (HALF + 9 * CPB) @(negedge clk);
        outReady = 1'b1;
        @(negedge clk);
        outReady = 1'b0;
      end
    join
    check(got.size() == 1 && got[0] == 8'h99, "R10 old accepted", got.size(), 1);
    check(outValid && outData == 8'h6B, "R10 new kept", outData, 8'h6B);
    accept("R7");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule